// File: doc/BRIEF.md
# Serial Peripheral Host Register Block

This block sits on a small memory-mapped register bus and acts as a host for a serial peripheral bus with up to four attached devices. Software programs a 16-bit control register that carries an enable, an interrupt enable, a chip-hold flag, a transfer-width request, a two-bit rate field and a two-bit device-select field. A bus write to the 8-bit data register starts a one-byte exchange with the selected device. Each exchange completes in exactly one cycle, so the block has no busy state.

The exchange is presented to the devices as a one-cycle strobe. The strobe carries the outgoing byte, the chip-hold flag and a first-byte marker. In that same cycle the strobed device returns its reply byte. The reply is kept per device, and a data read returns the reply of whichever device is selected at that moment. A chip select for each device stays asserted across bytes that are sent with the hold flag set. It drops after a byte that is sent with the hold flag clear, or when software disables the controller. This is how multi-byte device commands are framed. When the interrupt enable is set, every accepted data write produces a one-cycle interrupt pulse.

The bus has no back-pressure: every write is taken in the cycle it is presented, and read data is a combinational function of the address and size. The device side has no back-pressure either. A device must accept its strobe and drive its reply byte within that cycle.

Top module: `spi_bus_ctrl`

## Requirements
- R1: After reset the control register and all stored reply bytes are zero, and dev_strobe, dev_cs and irq are low.
- R2: A 16-bit or 32-bit write at offset 0x1C0 loads the control register with the written low half ANDed with 0xCF03, and all other control bits read as zero. Byte writes at 0x1C0 or 0x1C1 leave the control register unchanged.
- R3: While control bit 15 (enable) is clear, a data write produces no strobe and no interrupt, and a data read returns 0. A control write that leaves bit 15 clear releases every held chip select.
- R4: An accepted data write is a byte or 16-bit write at offset 0x1C2 while enabled. In the next cycle it raises exactly one dev_strobe bit, at index control[9:8], for one cycle.
- R5: The strobed byte on dev_tx is the low 8 bits of the written value. dev_hold equals control bit 11 as it was at the time of the write.
- R6: dev_first is high with a strobe exactly when the strobed device had no held chip select before that byte.
- R7: dev_cs of a device is high during its strobe. Afterwards it stays high exactly when that byte was sent with hold set, and it remains high until a byte with hold clear is sent to that device or the controller is disabled.
- R8: A data read while enabled returns the reply byte the currently selected device gave on its latest strobe. A device whose bit in DEV_MAP is clear is never strobed and reads as 0. With the default DEV_MAP of 4'b0111, device index 3 is unmapped.
- R9: Read layout is as follows. A 32-bit read at 0x1C0 returns the control value in bits 15:0 and the data byte in bits 23:16. A 16-bit read at 0x1C0 returns control, and a 16-bit read at 0x1C2 returns the data byte. A byte read at 0x1C0 returns control[7:0], at 0x1C1 returns control[15:8], and at 0x1C2 returns the data byte. Every other access returns 0.
- R10: irq is a one-cycle pulse in the cycle after each accepted data write when control bit 14 was set. This holds even for an unmapped device. No pulse is produced when bit 14 is clear.
- R11: Control bit 10 (wide-transfer request) is stored and reads back, but every transfer remains a single byte. Bit 7, the busy position, always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_size | input | 2 | Access size: 00 byte, 01 16-bit, 10 32-bit |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Combinational read data for bus_addr and bus_size |
| dev_strobe | output | 4 | One-cycle exchange strobe, one bit per device |
| dev_tx | output | 8 | Byte sent with the strobe |
| dev_hold | output | 1 | Chip-hold flag sent with the strobe |
| dev_first | output | 1 | Strobe opens a new command frame |
| dev_rx | input | 32 | Reply byte of device d on bits 8d+7:8d, sampled during its strobe |
| dev_cs | output | 4 | Chip select per device |
| irq | output | 1 | Transfer-complete interrupt pulse |

## Verification
Hold framing is tried with runs of bytes that have hold set and then a closing byte. This shows whether dev_first and dev_cs follow each device's own frame, and whether they instead follow a single shared flag. Switching device-select between transfers shows that reply bytes are stored per device and that reads follow the current selection. Writing all ones and byte-sized writes to the control register separates correct masking from missing masking and from wrong size decoding. Random mixes of control, data and read accesses against a bench model cover enable toggling, unmapped devices, the interrupt enable and every read size and offset.

// File: rtl/spi_bus_pkg.sv
package spi_bus_pkg;
  localparam int               SEL_W      = 2;
  localparam int               MAX_DEV    = 1 << SEL_W;
  localparam logic [15:0]      CTRL_WMASK = 16'hCF03;
  localparam int               B_EN       = 15;
  localparam int               B_IRQ_EN   = 14;
  localparam int               B_HOLD     = 11;
  localparam int               B_WIDE     = 10;
  localparam int               B_SEL_LO   = 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } bus_size_e;

  typedef struct packed {
    logic             en;
    logic             irq_en;
    logic             hold;
    logic             wide;
    logic [SEL_W-1:0] sel;
    logic [1:0]       rate;
  } ctrl_view_t;

  function automatic ctrl_view_t ctrl_view(input logic [15:0] c);
    ctrl_view_t v;
    v.en     = c[B_EN];
    v.irq_en = c[B_IRQ_EN];
    v.hold   = c[B_HOLD];
    v.wide   = c[B_WIDE];
    v.sel    = c[B_SEL_LO +: SEL_W];
    v.rate   = c[1:0];
    return v;
  endfunction
endpackage

// File: rtl/spi_ctrl_reg.sv
module spi_ctrl_reg
  import spi_bus_pkg::*;
#(
  parameter int                ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 12'h1C0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [15:0]       ctrl_q,
  output logic              cs_release
);
  logic hit_wr;

  // only 16-bit and 32-bit accesses reach the control register
  assign hit_wr = bus_wr && (bus_addr == CTRL_OFS) &&
                  ((bus_size == SZ_HALF) || (bus_size == SZ_WORD));

  assign cs_release = hit_wr && !bus_wdata[B_EN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctrl_q <= '0;
    else if (hit_wr) ctrl_q <= bus_wdata[15:0] & CTRL_WMASK;
  end
endmodule

// File: rtl/spi_dev_router.sv
module spi_dev_router
  import spi_bus_pkg::*;
#(
  parameter int                 N_DEV   = MAX_DEV,
  parameter logic [N_DEV-1:0]   DEV_MAP = '1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 xfer_req,
  input  logic [7:0]           xfer_byte,
  input  logic [SEL_W-1:0]     xfer_sel,
  input  logic                 xfer_hold,
  input  logic                 xfer_irq_en,
  input  logic                 cs_release,
  input  logic [N_DEV*8-1:0]   dev_rx,
  output logic [N_DEV-1:0]     dev_strobe,
  output logic [7:0]           dev_tx,
  output logic                 dev_hold,
  output logic                 dev_first,
  output logic [N_DEV-1:0]     dev_cs,
  output logic                 irq,
  output logic [N_DEV*8-1:0]   rx_last
);
  logic             pend_q;
  logic [SEL_W-1:0] sel_q;
  logic [7:0]       tx_q;
  logic             hold_q;
  logic             irq_q;
  logic [N_DEV-1:0] cs_q;
  logic [N_DEV-1:0] first_v;

  // transfer stage: the accepted write is presented one cycle later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      sel_q  <= '0;
      tx_q   <= '0;
      hold_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= xfer_req;
      irq_q  <= xfer_req && xfer_irq_en;
      if (xfer_req) begin
        sel_q  <= xfer_sel;
        tx_q   <= xfer_byte;
        hold_q <= xfer_hold;
      end
    end
  end

  for (genvar d = 0; d < N_DEV; d++) begin : g_dev
    if (DEV_MAP[d]) begin : g_mapped
      logic [7:0] last_q;

      assign dev_strobe[d] = pend_q && (sel_q == SEL_W'(d));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cs_q[d] <= 1'b0;
        else if (cs_release)     cs_q[d] <= 1'b0;
        else if (dev_strobe[d])  cs_q[d] <= hold_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             last_q <= '0;
        else if (dev_strobe[d]) last_q <= dev_rx[d*8 +: 8];
      end

      assign rx_last[d*8 +: 8] = last_q;
    end else begin : g_absent
      assign dev_strobe[d]     = 1'b0;
      assign cs_q[d]           = 1'b0;
      assign rx_last[d*8 +: 8] = 8'h00;
    end

    assign dev_cs[d]  = cs_q[d] | dev_strobe[d];
    assign first_v[d] = dev_strobe[d] & ~cs_q[d];
  end

  assign dev_tx    = tx_q;
  assign dev_hold  = hold_q;
  assign dev_first = |first_v;
  assign irq       = irq_q;
endmodule

// File: rtl/spi_read_mux.sv
module spi_read_mux
  import spi_bus_pkg::*;
#(
  parameter int                ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 12'h1C0,
  parameter int                N_DEV    = MAX_DEV,
  parameter logic [N_DEV-1:0]  DEV_MAP  = '1
) (
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [1:0]         bus_size,
  input  logic [15:0]        ctrl_q,
  input  logic [N_DEV*8-1:0] rx_last,
  output logic [31:0]        bus_rdata
);
  localparam logic [ADDR_W-1:0] CTRL_HI  = CTRL_OFS + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] DATA_OFS = CTRL_OFS + ADDR_W'(2);

  ctrl_view_t cv;
  logic [7:0] data_v;

  assign cv = ctrl_view(ctrl_q);

  always_comb begin
    data_v = 8'h00;
    for (int d = 0; d < N_DEV; d++)
      if (cv.en && DEV_MAP[d] && (cv.sel == SEL_W'(d)))
        data_v = rx_last[d*8 +: 8];
  end

  always_comb begin
    bus_rdata = 32'h0;
    unique case (bus_size)
      SZ_WORD: if (bus_addr == CTRL_OFS) bus_rdata = {8'h00, data_v, ctrl_q};
      SZ_HALF: begin
        if (bus_addr == CTRL_OFS)      bus_rdata = {16'h0, ctrl_q};
        else if (bus_addr == DATA_OFS) bus_rdata = {24'h0, data_v};
      end
      SZ_BYTE: begin
        if (bus_addr == CTRL_OFS)      bus_rdata = {24'h0, ctrl_q[7:0]};
        else if (bus_addr == CTRL_HI)  bus_rdata = {24'h0, ctrl_q[15:8]};
        else if (bus_addr == DATA_OFS) bus_rdata = {24'h0, data_v};
      end
      default: bus_rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/spi_bus_ctrl.sv
module spi_bus_ctrl
  import spi_bus_pkg::*;
#(
  parameter int                  ADDR_W   = 12,
  parameter logic [ADDR_W-1:0]   CTRL_OFS = 12'h1C0,
  parameter logic [MAX_DEV-1:0]  DEV_MAP  = 4'b0111
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [1:0]           bus_size,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [MAX_DEV-1:0]   dev_strobe,
  output logic [7:0]           dev_tx,
  output logic                 dev_hold,
  output logic                 dev_first,
  input  logic [MAX_DEV*8-1:0] dev_rx,
  output logic [MAX_DEV-1:0]   dev_cs,
  output logic                 irq
);
  localparam int                N_DEV    = MAX_DEV;
  localparam logic [ADDR_W-1:0] DATA_OFS = CTRL_OFS + ADDR_W'(2);

  logic [15:0]        ctrl_q;
  logic               cs_release;
  logic               xfer_req;
  logic [N_DEV*8-1:0] rx_last;
  ctrl_view_t         cv;

  assign cv = ctrl_view(ctrl_q);

  // data writes are taken only as byte or 16-bit accesses while enabled
  assign xfer_req = bus_wr && (bus_addr == DATA_OFS) && cv.en &&
                    ((bus_size == SZ_BYTE) || (bus_size == SZ_HALF));

  spi_ctrl_reg #(.ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_size   (bus_size),
    .bus_wdata  (bus_wdata),
    .ctrl_q     (ctrl_q),
    .cs_release (cs_release)
  );

  spi_dev_router #(.N_DEV(N_DEV), .DEV_MAP(DEV_MAP)) u_route (
    .clk         (clk),
    .rst_n       (rst_n),
    .xfer_req    (xfer_req),
    .xfer_byte   (bus_wdata[7:0]),
    .xfer_sel    (cv.sel),
    .xfer_hold   (cv.hold),
    .xfer_irq_en (cv.irq_en),
    .cs_release  (cs_release),
    .dev_rx      (dev_rx),
    .dev_strobe  (dev_strobe),
    .dev_tx      (dev_tx),
    .dev_hold    (dev_hold),
    .dev_first   (dev_first),
    .dev_cs      (dev_cs),
    .irq         (irq),
    .rx_last     (rx_last)
  );

  spi_read_mux #(
    .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .N_DEV(N_DEV), .DEV_MAP(DEV_MAP)
  ) u_rd (
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .ctrl_q    (ctrl_q),
    .rx_last   (rx_last),
    .bus_rdata (bus_rdata)
  );
endmodule

// File: rtl/spi_bus_ctrl_chk.sv
module spi_bus_ctrl_chk
  import spi_bus_pkg::*;
#(
  parameter int                ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 12'h1C0
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [1:0]          bus_size,
  input logic [31:0]         bus_rdata,
  input logic [15:0]         ctrl_q,
  input logic [MAX_DEV-1:0]  dev_strobe,
  input logic                irq
);
  localparam logic [ADDR_W-1:0] DATA_OFS = CTRL_OFS + ADDR_W'(2);

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_strobe)); // R4

  AST_STROBE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_strobe) |-> $past(bus_wr && (bus_addr == DATA_OFS) && ctrl_q[B_EN])); // R4

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(bus_wr && ctrl_q[B_EN] && ctrl_q[B_IRQ_EN])); // R10

  AST_DISABLED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[B_EN] && (bus_addr == DATA_OFS) && (bus_size != SZ_WORD))
      |-> (bus_rdata == 32'h0)); // R3

  AST_CTRL_READ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_addr == CTRL_OFS) && (bus_size == SZ_HALF))
      |-> ((bus_rdata[15:0] & ~CTRL_WMASK) == 16'h0)); // R2
endmodule

bind spi_bus_ctrl spi_bus_ctrl_chk #(.ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_size   (bus_size),
  .bus_rdata  (bus_rdata),
  .ctrl_q     (ctrl_q),
  .dev_strobe (dev_strobe),
  .irq        (irq)
);

// File: tb/tb_spi_bus_ctrl.sv
`timescale 1ns/1ps
module tb_spi_bus_ctrl;
  localparam logic [11:0] A_CTRL = 12'h1C0;
  localparam logic [11:0] A_CHI  = 12'h1C1;
  localparam logic [11:0] A_DATA = 12'h1C2;
  localparam logic [3:0]  MAP    = 4'b0111;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  dev_strobe;
  logic [7:0]  dev_tx;
  logic        dev_hold;
  logic        dev_first;
  logic [31:0] dev_rx;
  logic [3:0]  dev_cs;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] m_ctrl = '0;
  logic [3:0]  m_cs = '0;
  logic [7:0]  m_last [4];

  always #2 clk = ~clk;

  function automatic logic [7:0] dkey(input int d);
    return 8'h5A + 8'(d * 37);
  endfunction

  for (genvar d = 0; d < 4; d++) begin : g_model
    assign dev_rx[d*8 +: 8] = dev_tx ^ dkey(d);
  end

  spi_bus_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dev_strobe(dev_strobe), .dev_tx(dev_tx), .dev_hold(dev_hold),
    .dev_first(dev_first), .dev_rx(dev_rx), .dev_cs(dev_cs), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_data();
    logic [1:0] s = m_ctrl[9:8];
    if (!m_ctrl[15] || !MAP[s]) return 8'h00;
    return m_last[s];
  endfunction

  function automatic logic [31:0] exp_read(input logic [11:0] a, input logic [1:0] sz);
    logic [7:0] dv = exp_data();
    case (sz)
      2'b10: return (a == A_CTRL) ? {8'h00, dv, m_ctrl} : 32'h0;
      2'b01: return (a == A_CTRL) ? {16'h0, m_ctrl} : (a == A_DATA) ? {24'h0, dv} : 32'h0;
      2'b00: return (a == A_CTRL) ? {24'h0, m_ctrl[7:0]} :
                    (a == A_CHI)  ? {24'h0, m_ctrl[15:8]} :
                    (a == A_DATA) ? {24'h0, dv} : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  task automatic bus_read(input logic [11:0] a, input logic [1:0] sz, input string req);
    logic [31:0] e;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = a; bus_size = sz;
    #1;
    e = exp_read(a, sz);
    check(bus_rdata === e, req, bus_rdata, e);
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [1:0] sz, input logic [31:0] v);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == A_CTRL && (sz == 2'b01 || sz == 2'b10)) begin
      m_ctrl = v[15:0] & 16'hCF03;
      if (!m_ctrl[15]) m_cs = '0;
      check(dev_strobe == 4'h0, "R2 no strobe on control write", 32'(dev_strobe), 0);
      check(dev_cs == m_cs, "R3/R7 chip select after control write", 32'(dev_cs), 32'(m_cs));
    end else if (a == A_DATA && (sz == 2'b00 || sz == 2'b01) && m_ctrl[15]) begin
      logic [1:0] s = m_ctrl[9:8];
      logic [3:0] es = MAP[s] ? (4'b1 << s) : 4'b0;
      check(dev_strobe == es, "R4/R8 strobe select", 32'(dev_strobe), 32'(es));
      check(irq == m_ctrl[14], "R10 irq pulse", 32'(irq), 32'(m_ctrl[14]));
      check(dev_cs == (m_cs | es), "R7 chip select in strobe", 32'(dev_cs), 32'(m_cs | es));
      if (MAP[s]) begin
        check(dev_tx == v[7:0], "R5/R11 tx byte", 32'(dev_tx), 32'(v[7:0]));
        check(dev_hold == m_ctrl[11], "R5 hold flag", 32'(dev_hold), 32'(m_ctrl[11]));
        check(dev_first == !m_cs[s], "R6 first byte", 32'(dev_first), 32'(!m_cs[s]));
        m_cs[s]   = m_ctrl[11];
        m_last[s] = v[7:0] ^ dkey(int'(s));
      end
      @(negedge clk);
      check(irq == 1'b0, "R10 irq single cycle", 32'(irq), 0);
      check(dev_cs == m_cs, "R7 chip select after byte", 32'(dev_cs), 32'(m_cs));
    end else begin
      check(dev_strobe == 4'h0, "R3 ignored write no strobe", 32'(dev_strobe), 0);
      check(irq == 1'b0, "R3 ignored write no irq", 32'(irq), 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5A17);
    for (int d = 0; d < 4; d++) m_last[d] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    check(dev_strobe == 0 && dev_cs == 0 && irq == 0, "R1 outputs idle",
          {dev_strobe, dev_cs, 23'h0, irq}, 0);
    bus_read(A_CTRL, 2'b10, "R1 reset read");
    // R2/R11 masking, wide bit stored, busy bit zero
    bus_write(A_CTRL, 2'b01, 32'h0000_FFFF);
    bus_read(A_CTRL, 2'b01, "R2/R11 masked control");
    bus_write(A_CTRL, 2'b00, 32'h0);
    bus_read(A_CTRL, 2'b01, "R2 byte write ignored");
    bus_write(A_CHI, 2'b00, 32'h0);
    bus_read(A_CHI, 2'b00, "R2 high byte write ignored");
    // R3 disabled
    bus_write(A_CTRL, 2'b10, 32'h0000_4100);
    bus_write(A_DATA, 2'b00, 32'h77);
    bus_read(A_DATA, 2'b00, "R3 disabled read zero");
    // R4..R7 framed command on device 1
    bus_write(A_CTRL, 2'b01, 32'h0000_C900);
    bus_write(A_DATA, 2'b01, 32'h0000_ABCD);
    bus_write(A_DATA, 2'b00, 32'h0000_0011);
    bus_write(A_DATA, 2'b00, 32'h0000_0022);
    bus_write(A_CTRL, 2'b01, 32'h0000_8100);
    bus_write(A_DATA, 2'b00, 32'h0000_0033);
    bus_read(A_DATA, 2'b00, "R8 reply byte");
    bus_read(A_CTRL, 2'b10, "R9 word layout");
    // R8 per-device storage and unmapped device
    bus_write(A_CTRL, 2'b01, 32'h0000_8A00);
    bus_write(A_DATA, 2'b00, 32'h0000_0044);
    bus_write(A_CTRL, 2'b01, 32'h0000_8100);
    bus_read(A_DATA, 2'b01, "R8 device 1 kept");
    bus_write(A_CTRL, 2'b01, 32'h0000_C300);
    bus_write(A_DATA, 2'b00, 32'h0000_0055);
    bus_read(A_DATA, 2'b00, "R8 unmapped reads zero");
    // R3/R7 release of held select by disabling
    bus_write(A_CTRL, 2'b01, 32'h0000_8800);
    bus_write(A_DATA, 2'b00, 32'h0000_0066);
    bus_write(A_CTRL, 2'b01, 32'h0000_0800);
    // R11 wide request still sends one byte
    bus_write(A_CTRL, 2'b01, 32'h0000_8600);
    bus_write(A_DATA, 2'b01, 32'h0000_1234);
    bus_read(A_CTRL, 2'b00, "R9 byte read low");
    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      int op = $urandom_range(0, 9);
      logic [1:0] sz = 2'($urandom_range(0, 2));
      logic [11:0] a = 12'h1C0 + 12'($urandom_range(0, 3));
      if (op < 2) bus_write(A_CTRL, $urandom_range(0, 1) ? 2'b01 : 2'b10,
                            ($urandom & 32'hFFFF_0F00) | 32'h8000 * $urandom_range(0, 1) |
                            32'h8000 * ((op == 1) ? 1 : 0));
      else if (op < 6) bus_write(A_DATA, 2'($urandom_range(0, 1)), $urandom);
      else if (op < 7) bus_write(a, sz, $urandom);
      else bus_read(a, sz, "R9 random read");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule